// File: doc/BRIEF.md
# Burst-to-Word-Stream Protocol Shell

This block sits between a memory-mapped initiator port and a word-wide streaming network channel. On the bus side it takes a burst command (direction, address, burst length), write data beats and a read data return channel. On the network side it has one outgoing request word stream and one incoming response word stream. Every handshake on both sides uses valid/accept flow control, and the block never drops a word.

A command becomes a short message on the request stream. Two header words go first: a command word carrying the direction flag and the burst length, then the address. A write then forwards its `b` data beats as payload words, one word per beat. A read sends only the two headers. The block then takes exactly `b` words from the response stream and hands them, in order, to the bus read data channel. A write gets no response words.

Only one transaction is in flight at a time. A new command is accepted in the cycle after the previous transaction completes. A write completes with its last payload word. A read completes with its last returned data beat.

Top module: `burst_word_shell`

## Requirements
- R1: After reset, and whenever no transaction is in progress, `cmd_ready` is 1 and `req_valid`, `rdat_valid`, `wdat_ready` and `rsp_accept` are all 0.
- R2: The first request word of every transaction is the command word. Bit 31 is 1 for a read and 0 for a write. Bits 7:0 hold the burst length. Bits 30:8 are zero.
- R3: The second request word is the 32-bit burst address.
- R4: A read request consists of exactly the two header words and nothing more. `wdat_ready` stays 0 for the whole read transaction.
- R5: A write request is the two header words followed by exactly `b` payload words, equal to the write data beats in bus order. During the payload phase `req_valid` follows `wdat_valid` and `wdat_ready` follows `req_accept`.
- R6: After both read header words have been accepted, exactly `b` response words are passed to `rdat_data` in arrival order. `rsp_accept` follows `rdat_ready` and `rdat_valid` follows `rsp_valid`. Before that point `rsp_accept` is 0.
- R7: A write takes no words from the response stream: `rsp_accept` stays 0 from command acceptance until the transaction completes.
- R8: A request word offered with `req_accept` low stays offered, unchanged, in the next cycle. No word is lost or repeated under any pattern of stalls on either side.
- R9: After a command is accepted, `cmd_ready` stays 0 until the transaction completes, and returns to 1 in the cycle after the completing handshake.
- R10: Burst lengths 1 to 255 are supported, including both end values. A length of 0 is outside the contract.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Burst command offered |
| cmd_ready | output | 1 | Shell can take a command |
| cmd_is_read | input | 1 | 1 = read burst, 0 = write burst |
| cmd_addr | input | 32 | Burst start address |
| cmd_len | input | 8 | Burst length in beats (1..255) |
| wdat_valid | input | 1 | Write data beat offered |
| wdat_ready | output | 1 | Write data beat taken |
| wdat_data | input | 32 | Write data beat |
| rdat_valid | output | 1 | Read data beat offered |
| rdat_ready | input | 1 | Read data beat taken |
| rdat_data | output | 32 | Read data beat |
| req_valid | output | 1 | Request word offered to the network |
| req_accept | input | 1 | Network takes the request word |
| req_word | output | 32 | Request stream word |
| rsp_valid | input | 1 | Response word offered by the network |
| rsp_accept | output | 1 | Shell takes the response word |
| rsp_word | input | 32 | Response stream word |

## Verification
Two events can meet in one cycle. The handshake that completes a transaction (the last payload word of a write, or the last read beat) can coincide with a new command already waiting on `cmd_valid`. The bench keeps the next command offered throughout every transaction, so that collision comes up at every boundary. It requires `cmd_ready` to stay low in the completing cycle and to be high in the very next one. Payload forwarding can also coincide with stalls on both its sides. The bench draws `req_accept`, `wdat_valid`, `rsp_valid` and `rdat_ready` at random, per cycle, against a word-by-word expected sequence computed from address and beat index. It also drives junk on the write data and response inputs whenever the current transaction must ignore them.

// File: rtl/bws_pkg.sv
package bws_pkg;
    localparam int WORD_W   = 32;
    localparam int LEN_W    = 8;
    localparam int FLAG_BIT = WORD_W - 1;
    localparam int HDR_WORDS = 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LEN_W-1:0]  len_t;

    typedef struct packed {
        logic  is_read;
        word_t addr;
        len_t  len;
    } txn_t;

    typedef enum logic [1:0] {
        SH_IDLE = 2'd0,
        SH_SEND = 2'd1,
        SH_RECV = 2'd2
    } shell_st_t;

    typedef enum logic [1:0] {
        SP_CMD  = 2'd0,
        SP_ADDR = 2'd1,
        SP_DATA = 2'd2
    } ser_ph_t;

    function automatic word_t make_cmd_word(input txn_t t);
        word_t w;
        w = '0;
        w[FLAG_BIT]  = t.is_read;
        w[LEN_W-1:0] = t.len;
        return w;
    endfunction
endpackage

// File: rtl/bws_req_ser.sv
module bws_req_ser
    import bws_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  txn_t  txn,
    input  logic  wdat_valid,
    input  word_t wdat_data,
    output logic  wdat_ready,
    output logic  req_valid,
    input  logic  req_accept,
    output word_t req_word,
    output logic  done
);
    ser_ph_t ph;
    logic    active;
    len_t    sent;
    logic    fire;

    always_comb begin
        req_valid  = 1'b0;
        req_word   = '0;
        wdat_ready = 1'b0;
        done       = 1'b0;
        if (active) begin
            unique case (ph)
                SP_CMD: begin
                    req_valid = 1'b1;
                    req_word  = make_cmd_word(txn);
                end
                SP_ADDR: begin
                    req_valid = 1'b1;
                    req_word  = txn.addr;
                    done      = req_accept && txn.is_read;
                end
                SP_DATA: begin
                    req_valid  = wdat_valid;
                    req_word   = wdat_data;
                    wdat_ready = req_accept;
                    done       = wdat_valid && req_accept &&
                                 (sent + len_t'(1) == txn.len);
                end
                default: ;
            endcase
        end
    end

    assign fire = req_valid && req_accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            ph     <= SP_CMD;
            sent   <= '0;
        end else if (start) begin
            active <= 1'b1;
            ph     <= SP_CMD;
            sent   <= '0;
        end else if (active && fire) begin
            unique case (ph)
                SP_CMD:  ph <= SP_ADDR;
                SP_ADDR: begin
                    if (txn.is_read) active <= 1'b0;
                    else             ph     <= SP_DATA;
                end
                SP_DATA: begin
                    sent <= sent + len_t'(1);
                    if (done) active <= 1'b0;
                end
                default: ph <= SP_CMD;
            endcase
        end
    end

    // R8: a stalled header word is held and unchanged
    assert_hdr_held_R8: assert property (@(posedge clk) disable iff (rst)
        (active && ph != SP_DATA && !req_accept) |=> (req_valid && $stable(req_word)));

    // R5: payload beat counter never reaches the burst length while sending
    assert_beats_bounded_R5: assert property (@(posedge clk) disable iff (rst)
        (active && ph == SP_DATA) |-> (sent < txn.len));

    // R4: a read never enters the payload phase
    assert_read_no_payload_R4: assert property (@(posedge clk) disable iff (rst)
        (active && txn.is_read) |-> (ph != SP_DATA));
endmodule

// File: rtl/bws_rsp_col.sv
module bws_rsp_col
    import bws_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  len_t  len,
    input  logic  rsp_valid,
    input  word_t rsp_word,
    output logic  rsp_accept,
    output logic  rdat_valid,
    output word_t rdat_data,
    input  logic  rdat_ready,
    output logic  done
);
    logic active;
    len_t got;
    logic beat;

    assign rdat_valid = active && rsp_valid;
    assign rdat_data  = rsp_word;
    assign rsp_accept = active && rdat_ready;
    assign beat       = active && rsp_valid && rdat_ready;
    assign done       = beat && (got + len_t'(1) == len);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            got    <= '0;
        end else if (start) begin
            active <= 1'b1;
            got    <= '0;
        end else if (beat) begin
            got <= got + len_t'(1);
            if (done) active <= 1'b0;
        end
    end

    // R6: never more beats collected than the burst length
    assert_rsp_count_R6: assert property (@(posedge clk) disable iff (rst)
        active |-> (got < len));

    // R6: a beat is accepted from the network only when the bus takes it
    assert_rsp_pairs_R6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_accept) |-> (rdat_valid && rdat_ready));
endmodule

// File: rtl/burst_word_shell.sv
module burst_word_shell
    import bws_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_is_read,
    input  logic [WORD_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              wdat_valid,
    output logic              wdat_ready,
    input  logic [WORD_W-1:0] wdat_data,
    output logic              rdat_valid,
    input  logic              rdat_ready,
    output logic [WORD_W-1:0] rdat_data,
    output logic              req_valid,
    input  logic              req_accept,
    output logic [WORD_W-1:0] req_word,
    input  logic              rsp_valid,
    output logic              rsp_accept,
    input  logic [WORD_W-1:0] rsp_word
);
    shell_st_t st;
    txn_t      cur;
    logic      cmd_fire;
    logic      ser_done;
    logic      col_done;
    logic      col_start;

    assign cmd_ready = (st == SH_IDLE);
    assign cmd_fire  = cmd_valid && cmd_ready;
    assign col_start = (st == SH_SEND) && ser_done && cur.is_read;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SH_IDLE;
            cur <= '0;
        end else begin
            unique case (st)
                SH_IDLE: if (cmd_fire) begin
                    cur <= '{is_read: cmd_is_read, addr: cmd_addr, len: cmd_len};
                    st  <= SH_SEND;
                end
                SH_SEND: if (ser_done) st <= cur.is_read ? SH_RECV : SH_IDLE;
                SH_RECV: if (col_done) st <= SH_IDLE;
                default: st <= SH_IDLE;
            endcase
        end
    end

    bws_req_ser u_ser (
        .clk        (clk),
        .rst        (rst),
        .start      (cmd_fire),
        .txn        (cur),
        .wdat_valid (wdat_valid),
        .wdat_data  (wdat_data),
        .wdat_ready (wdat_ready),
        .req_valid  (req_valid),
        .req_accept (req_accept),
        .req_word   (req_word),
        .done       (ser_done)
    );

    bws_rsp_col u_col (
        .clk        (clk),
        .rst        (rst),
        .start      (col_start),
        .len        (cur.len),
        .rsp_valid  (rsp_valid),
        .rsp_word   (rsp_word),
        .rsp_accept (rsp_accept),
        .rdat_valid (rdat_valid),
        .rdat_data  (rdat_data),
        .rdat_ready (rdat_ready),
        .done       (col_done)
    );

    // R9: one transaction at a time
    assert_single_txn_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_fire |=> !cmd_ready);

    // R10: burst length inside the supported range
    assert_len_legal_R10: assert property (@(posedge clk) disable iff (rst)
        cmd_fire |-> (cmd_len != '0));

    // R7: a write never draws on the response stream
    assert_no_write_rsp_R7: assert property (@(posedge clk) disable iff (rst)
        (st != SH_IDLE && !cur.is_read) |-> !rsp_accept);

    // R4: a read never takes write data
    assert_read_no_wdata_R4: assert property (@(posedge clk) disable iff (rst)
        (st != SH_IDLE && cur.is_read) |-> !wdat_ready);

    // R1: idle shell offers and accepts nothing on the streams
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (st == SH_IDLE) |-> (!req_valid && !rdat_valid && !rsp_accept && !wdat_ready));

    // R6: response words are only taken after the read headers left
    assert_rsp_after_hdr_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_accept |-> (st == SH_RECV));
endmodule

// File: tb/sim_burst_word_shell.sv
module sim_burst_word_shell;
    import bws_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic  cmd_valid, cmd_ready, cmd_is_read;
    word_t cmd_addr;
    len_t  cmd_len;
    logic  wdat_valid, wdat_ready;
    word_t wdat_data;
    logic  rdat_valid, rdat_ready;
    word_t rdat_data;
    logic  req_valid, req_accept;
    word_t req_word;
    logic  rsp_valid, rsp_accept;
    word_t rsp_word;

    burst_word_shell u0 (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_is_read(cmd_is_read),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .wdat_valid(wdat_valid), .wdat_ready(wdat_ready), .wdat_data(wdat_data),
        .rdat_valid(rdat_valid), .rdat_ready(rdat_ready), .rdat_data(rdat_data),
        .req_valid(req_valid), .req_accept(req_accept), .req_word(req_word),
        .rsp_valid(rsp_valid), .rsp_accept(rsp_accept), .rsp_word(rsp_word)
    );

    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input word_t act, input word_t exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic word_t wr_word(input word_t a, input int i);
        return a ^ (word_t'(i + 1) * 32'h9E37_79B9);
    endfunction

    function automatic word_t rd_word(input word_t a, input int i);
        return ~a + word_t'(i) * 32'h0100_0193;
    endfunction

    int t_rd[64];
    int t_len[64];
    int t_pct[64];
    word_t t_addr[64];
    int n_txn = 0;

    initial begin
        int lens[7] = '{1, 2, 3, 4, 17, 254, 255};
        bit    active = 1'b0;
        int    next = 0;
        int    a_rd = 0, a_len = 0, a_pct = 0, total = 0;
        word_t a_addr = '0;
        int    reqidx = 0, widx = 0, rsent = 0, rgot = 0;
        bit    prev_stall = 1'b0;
        word_t prev_word = '0;
        bit    hold_cmd = 1'b0, hold_w = 1'b0, hold_r = 1'b0;
        int    cyc = 0;
        word_t exp_w;

        for (int p = 0; p < 2; p++)
            for (int l = 0; l < 7; l++)
                for (int op = 0; op < 2; op++) begin
                    t_rd[n_txn]   = op;
                    t_len[n_txn]  = lens[l];
                    t_pct[n_txn]  = p ? 60 : 20;
                    t_addr[n_txn] = 32'h4000_0000 + word_t'(n_txn) * 32'h0001_0104;
                    n_txn++;
                end

        cmd_valid = 0; cmd_is_read = 0; cmd_addr = '0; cmd_len = '0;
        wdat_valid = 0; wdat_data = '0; rdat_ready = 0;
        req_accept = 0; rsp_valid = 0; rsp_word = '0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk(cmd_ready == 1'b1, "R1 cmd_ready after reset", word_t'(cmd_ready), 32'd1);
        chk({req_valid, rdat_valid, wdat_ready, rsp_accept} == 4'b0,
            "R1 stream outputs after reset",
            word_t'({req_valid, rdat_valid, wdat_ready, rsp_accept}), 32'd0);

        while (!(next == n_txn && !active)) begin
            @(negedge clk);
            cyc++;
            if (cyc > 190000) begin
                chk(1'b0, "R9 watchdog expired", word_t'(cyc), 32'd0);
                break;
            end

            // command: keep a pending one offered across transaction ends
            if (next < n_txn) begin
                cmd_valid   = hold_cmd || ($urandom_range(0, 3) != 0);
                cmd_is_read = t_rd[next][0];
                cmd_addr    = t_addr[next];
                cmd_len     = len_t'(t_len[next]);
            end else begin
                cmd_valid = 1'b0;
            end

            req_accept = ($urandom_range(0, 99) >= a_pct);
            rdat_ready = ($urandom_range(0, 99) >= a_pct);

            if (active && a_rd == 0) begin
                wdat_valid = (widx < a_len) && (hold_w || ($urandom_range(0, 99) >= a_pct));
                wdat_data  = wr_word(a_addr, widx);
            end else if (active) begin
                wdat_valid = 1'b1;
                wdat_data  = 32'hDEAD_BEEF;
            end else begin
                wdat_valid = 1'b0;
            end

            if (active && a_rd != 0 && reqidx >= HDR_WORDS) begin
                rsp_valid = (rsent < a_len) && (hold_r || ($urandom_range(0, 99) >= a_pct));
                rsp_word  = rd_word(a_addr, rsent);
            end else if (active) begin
                rsp_valid = 1'b1;
                rsp_word  = 32'hBAD0_0BAD;
            end else begin
                rsp_valid = 1'b0;
            end

            #1;

            hold_cmd = cmd_valid && !cmd_ready;
            hold_w   = wdat_valid && !wdat_ready && active && a_rd == 0;
            hold_r   = rsp_valid && !rsp_accept && active && a_rd != 0 && reqidx >= HDR_WORDS;

            // R9: ready exactly when no transaction is open
            chk(cmd_ready == !active, "R9 cmd_ready vs open transaction",
                word_t'(cmd_ready), word_t'(!active));

            if (!active) begin
                chk({req_valid, rdat_valid, wdat_ready, rsp_accept} == 4'b0,
                    "R1 idle stream outputs",
                    word_t'({req_valid, rdat_valid, wdat_ready, rsp_accept}), 32'd0);
                if (cmd_valid && cmd_ready) begin
                    a_rd = t_rd[next]; a_len = t_len[next];
                    a_pct = t_pct[next]; a_addr = t_addr[next];
                    total = a_rd ? HDR_WORDS : HDR_WORDS + a_len;
                    reqidx = 0; widx = 0; rsent = 0; rgot = 0;
                    prev_stall = 1'b0; hold_w = 1'b0; hold_r = 1'b0;
                    active = 1'b1;
                    next++;
                end
            end else begin
                if (a_rd != 0) begin
                    chk(!wdat_ready, "R4 read takes no write data", word_t'(wdat_ready), 32'd0);
                    if (reqidx < HDR_WORDS)
                        chk(!rsp_accept, "R6 response before headers", word_t'(rsp_accept), 32'd0);
                    else
                        chk(rdat_valid == rsp_valid && rsp_accept == rdat_ready,
                            "R6 response pass-through",
                            word_t'({rdat_valid, rsp_accept}), word_t'({rsp_valid, rdat_ready}));
                end else begin
                    chk(!rsp_accept, "R7 write takes no response", word_t'(rsp_accept), 32'd0);
                    if (reqidx >= HDR_WORDS)
                        chk(wdat_ready == req_accept && req_valid == wdat_valid,
                            "R5 payload pass-through",
                            word_t'({wdat_ready, req_valid}), word_t'({req_accept, wdat_valid}));
                end

                if (reqidx >= total)
                    chk(!req_valid, "R4 no request word past the message", word_t'(req_valid), 32'd0);

                if (prev_stall)
                    chk(req_valid && req_word == prev_word, "R8 stalled word held",
                        req_word, prev_word);
                prev_stall = req_valid && !req_accept;
                prev_word  = req_word;

                if (req_valid && req_accept && reqidx < total) begin
                    if (reqidx == 0) begin
                        exp_w = (a_rd != 0 ? 32'h8000_0000 : 32'h0) | word_t'(a_len);
                        chk(req_word == exp_w, "R2 command word", req_word, exp_w);
                    end else if (reqidx == 1) begin
                        chk(req_word == a_addr, "R3 address word", req_word, a_addr);
                    end else begin
                        exp_w = wr_word(a_addr, reqidx - HDR_WORDS);
                        chk(req_word == exp_w, "R5 payload word R10 length sweep", req_word, exp_w);
                    end
                    reqidx++;
                end

                if (wdat_valid && wdat_ready) widx++;
                if (rsp_valid && rsp_accept) rsent++;
                if (rdat_valid && rdat_ready) begin
                    exp_w = rd_word(a_addr, rgot);
                    chk(rdat_data == exp_w, "R6 read beat R10 length sweep", rdat_data, exp_w);
                    rgot++;
                end

                if (a_rd == 0 && reqidx == total) active = 1'b0;
                if (a_rd != 0 && rgot == a_len) begin
                    chk(rsent == a_len, "R6 response word count", word_t'(rsent), word_t'(a_len));
                    active = 1'b0;
                end
            end
        end

        chk(next == n_txn, "R10 all bursts completed", word_t'(next), word_t'(n_txn));
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule